// File: doc/BRIEF.md
# Triggered command queue controller

This block holds a small FIFO of conversion commands and decides when those commands may leave for a downstream converter's command buffer. Software loads commands through a push port and controls the queue through one write port. That port carries a 4-bit operating mode, an arm strobe that starts a single scan, and a flush strobe that empties the queue. Commands leave through a valid/ready handshake, and only while the queue is armed and the selected trigger condition holds.

The trigger condition depends on the mode. In the software mode the queue is released as soon as it is armed. The two level-gated modes also require the external trigger input to sit at the selected level, low or high. A scan ends when a command carrying the end-of-queue marker is handed off, or when the last stored command leaves. The queue then returns to idle and must be armed again.

Mode changes follow a strict rule. Once a mode other than disabled is active, the only change accepted is to disabled. Any other change is dropped and a sticky error flag is set. The flush strobe is honoured only while the queue is disabled and idle. A flush discards only the commands still stored in the queue; commands already accepted downstream are not affected.

Top module: `cmdq_trig_ctrl`

## Requirements
- R1: Mode codes are 0 = disabled, 1 = software-started single scan, 2 = single scan gated by trigger low, 3 = single scan gated by trigger high. A write carrying a code from 4 to 15 leaves the mode unchanged and sets the sticky `mode_err`.
- R2: A write with the arm bit (`ctl_wdata[4]`) set sets the scan flag only when the mode after that write is 1, 2 or 3. It has no effect when that mode is disabled or when the scan flag is already set.
- R3: `ctl_rdata` layout: [3:0] mode, [4] and [5] always 0, [6] scan flag, [7] mode error. Writing 0 to the arm bit or to the flush bit changes nothing.
- R4: A flush (`ctl_wdata[5]` = 1) while the mode is disabled and the queue is idle sets `entry_cnt` to 0. It also returns both the write and read positions to the first slot, so the next command pushed is the next one handed off.
- R5: A flush while the mode is not disabled, or while the queue is not idle, is ignored and the stored commands remain.
- R6: While the mode is not disabled, a write of any code other than 0 or the current code leaves the mode unchanged and sets `mode_err`. A write of 0 is always accepted. Any legal code is accepted when the mode is disabled and the queue is idle. `mode_err` stays set until reset.
- R7: Switching the mode to disabled clears the scan flag, returns `qstate` to idle and stops hand-offs, and keeps the stored commands.
- R8: `qstate` is 00 when idle (scan flag clear), 01 when waiting (armed, trigger condition false) and 10 when triggered. The trigger condition is always true in mode 1, true in mode 2 when `trig_in` = 0, and true in mode 3 when `trig_in` = 1. `out_valid` is high only while triggered with at least one command stored.
- R9: Handing off a command whose top bit (`out_data[CMD_W-1]`) is 1, or handing off the last stored command, clears the scan flag and returns `qstate` to idle from the next cycle.
- R10: A push while `entry_cnt` equals DEPTH (default 4) is dropped and sets the sticky `push_ovf`; `entry_cnt` never exceeds DEPTH.
- R11: Commands are handed off in push order, one per cycle in which `out_valid` and `out_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 6 | Control write data: mode [3:0], arm [4], flush [5] |
| ctl_rdata | output | 8 | Control read data (layout in R3) |
| push_valid | input | 1 | Push a command this cycle |
| push_data | input | CMD_W | Command to push; top bit marks end of queue |
| trig_in | input | 1 | External trigger level |
| out_valid | output | 1 | Head command offered downstream |
| out_ready | input | 1 | Downstream accepts the offered command |
| out_data | output | CMD_W | Head command |
| scan_active | output | 1 | Scan flag |
| entry_cnt | output | $clog2(DEPTH+1) | Commands stored |
| qstate | output | 2 | Queue state: 00 idle, 01 waiting, 10 triggered |
| mode_err | output | 1 | Sticky illegal-mode-write flag |
| push_ovf | output | 1 | Sticky dropped-push flag |

## Verification
The assertions take for granted that `trig_in`, `out_ready` and all strobes are synchronous to `clk`. They also assume a push never coincides with a flush, and that `out_ready` needs no stability once `out_valid` is high. The stimulus drives every input on the falling edge. It pushes only while the queue is disabled, not ready or waiting, and it changes `trig_in` only between writes, so each hand-off can be predicted from the scoreboard queue alone.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;

   // mode codes (decoded by the trigger gate and the control register)
   typedef enum logic [3:0] {
      QM_OFF     = 4'd0,
      QM_SW      = 4'd1,
      QM_TRIG_LO = 4'd2,
      QM_TRIG_HI = 4'd3
   } qmode_e;

   typedef enum logic [1:0] {
      QS_IDLE = 2'b00,
      QS_WAIT = 2'b01,
      QS_TRIG = 2'b10
   } qstat_e;

   localparam int WR_W      = 6;
   localparam int RD_W      = 8;
   localparam int MODE_LSB  = 0;
   localparam int ARM_BIT   = 4;
   localparam int FLUSH_BIT = 5;
   localparam int SCAN_BIT  = 6;
   localparam int ERR_BIT   = 7;

   function automatic logic mode_known(input logic [3:0] m);
      return (m <= 4'd3);
   endfunction

   function automatic logic mode_single(input logic [3:0] m);
      return (m != 4'd0) && (m <= 4'd3);
   endfunction

endpackage

// File: rtl/cmdq_fifo.sv
`timescale 1ns/1ps
module cmdq_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic [W-1:0]                 push_data_i,
   input  logic                         pop_i,
   input  logic                         flush_i,
   output logic [W-1:0]                 head_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o,
   output logic                         empty_o,
   output logic                         drop_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   initial begin
      assert (DEPTH >= 2) else $error("cmdq_fifo: DEPTH must be at least 2");
      assert (W >= 2)     else $error("cmdq_fifo: W must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count_q;
   logic             full, push_ok, pop_ok;

   assign full    = (count_q == CNT_FULL);
   assign empty_o = (count_q == '0);
   assign push_ok = push_i & ~full & ~flush_i;
   assign pop_ok  = pop_i & ~empty_o & ~flush_i;
   assign drop_o  = push_i & full & ~flush_i;

   // pointer advance: natural wrap for power-of-two depth, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (push_ok && wr_ptr == PTR_W'(e)) mem[e] <= push_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else if (flush_i) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_o  = mem[rd_ptr];
   assign count_o = count_q;

   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_FULL);
   p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop_i && !flush_i) |=> (count_q == CNT_FULL));
   p_flush_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (count_q == '0));
   p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (count_q != '0));

endmodule

// File: rtl/cmdq_ctrl.sv
`timescale 1ns/1ps
module cmdq_ctrl
   import cmdq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [WR_W-1:0] wdata_i,
   input  logic            xfer_i,
   input  logic            xfer_last_i,
   output logic [3:0]      mode_o,
   output logic            scan_o,
   output logic            err_o,
   output logic            flush_o
);
   logic [3:0] req_mode, mode_q, mode_d;
   logic       scan_q, scan_d, err_q;
   logic       change_ok, arm_req, flush_req, to_off;

   assign req_mode  = wdata_i[MODE_LSB +: 4];
   assign arm_req   = wr_i & wdata_i[ARM_BIT];
   assign flush_req = wr_i & wdata_i[FLUSH_BIT];

   // mode write legality: same code, disable, or any known code from disabled+idle
   always_comb begin
      change_ok = 1'b0;
      if (req_mode == mode_q)
         change_ok = 1'b1;
      else if (req_mode == QM_OFF)
         change_ok = 1'b1;
      else if (mode_q == QM_OFF && !scan_q && mode_known(req_mode))
         change_ok = 1'b1;
   end

   assign mode_d = (wr_i && change_ok) ? req_mode : mode_q;
   assign to_off = wr_i & change_ok & (req_mode == QM_OFF);

   // scan flag: disable and end-of-scan win over arming
   always_comb begin
      scan_d = scan_q;
      if (to_off)
         scan_d = 1'b0;
      else if (xfer_i && xfer_last_i)
         scan_d = 1'b0;
      else if (arm_req && !scan_q && mode_single(mode_d))
         scan_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= QM_OFF;
         scan_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         scan_q <= scan_d;
         if (wr_i && !change_ok) err_q <= 1'b1;
      end
   end

   assign flush_o = flush_req & (mode_q == QM_OFF) & ~scan_q;
   assign mode_o  = mode_q;
   assign scan_o  = scan_q;
   assign err_o   = err_q;

   p_mode_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_known(mode_q));
   p_arm_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_q) |-> mode_single(mode_q));
   p_mode_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> ($past(mode_q) == QM_OFF || mode_q == QM_OFF));
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == QM_OFF) |-> !scan_q);

endmodule

// File: rtl/cmdq_gate.sv
`timescale 1ns/1ps
module cmdq_gate
   import cmdq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode_i,
   input  logic       scan_i,
   input  logic       trig_i,
   input  logic       empty_i,
   output logic [1:0] qstate_o,
   output logic       valid_o
);
   logic lvl_ok;

   always_comb begin
      case (mode_i)
         QM_SW:      lvl_ok = 1'b1;
         QM_TRIG_LO: lvl_ok = ~trig_i;
         QM_TRIG_HI: lvl_ok = trig_i;
         default:    lvl_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!scan_i)     qstate_o = QS_IDLE;
      else if (lvl_ok) qstate_o = QS_TRIG;
      else             qstate_o = QS_WAIT;
   end

   assign valid_o = (qstate_o == QS_TRIG) & ~empty_i;

   p_lo_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && mode_i == QM_TRIG_LO) |-> !trig_i);
   p_hi_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && mode_i == QM_TRIG_HI) |-> trig_i);
   p_valid_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (scan_i && mode_i != QM_OFF));

endmodule

// File: rtl/cmdq_trig_ctrl.sv
`timescale 1ns/1ps
module cmdq_trig_ctrl
   import cmdq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CMD_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ctl_wr,
   input  logic [5:0]                  ctl_wdata,
   output logic [7:0]                  ctl_rdata,
   input  logic                        push_valid,
   input  logic [CMD_W-1:0]            push_data,
   input  logic                        trig_in,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [CMD_W-1:0]            out_data,
   output logic                        scan_active,
   output logic [$clog2(DEPTH+1)-1:0]  entry_cnt,
   output logic [1:0]                  qstate,
   output logic                        mode_err,
   output logic                        push_ovf
);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam int EOQ_B = CMD_W - 1;

   initial begin
      assert (WR_W == 6) else $error("cmdq_trig_ctrl: write layout mismatch");
      assert (RD_W == 8) else $error("cmdq_trig_ctrl: read layout mismatch");
   end

   logic [3:0]       mode;
   logic             scan, err, flush, xfer, xfer_last, empty, drop, ovf_q;
   logic [CNT_W-1:0] cnt;
   logic [CMD_W-1:0] head;

   assign xfer      = out_valid & out_ready;
   assign xfer_last = head[EOQ_B] | (cnt == CNT_W'(1));

   cmdq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (ctl_wr),
      .wdata_i     (ctl_wdata),
      .xfer_i      (xfer),
      .xfer_last_i (xfer_last),
      .mode_o      (mode),
      .scan_o      (scan),
      .err_o       (err),
      .flush_o     (flush)
   );

   cmdq_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_valid),
      .push_data_i (push_data),
      .pop_i       (xfer),
      .flush_i     (flush),
      .head_o      (head),
      .count_o     (cnt),
      .empty_o     (empty),
      .drop_o      (drop)
   );

   cmdq_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .scan_i   (scan),
      .trig_i   (trig_in),
      .empty_i  (empty),
      .qstate_o (qstate),
      .valid_o  (out_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
   end

   always_comb begin
      ctl_rdata                      = '0;
      ctl_rdata[MODE_LSB +: 4]       = mode;
      ctl_rdata[SCAN_BIT]            = scan;
      ctl_rdata[ERR_BIT]             = err;
   end

   assign out_data    = head;
   assign scan_active = scan;
   assign entry_cnt   = cnt;
   assign mode_err    = err;
   assign push_ovf    = ovf_q;

   p_strobes_read0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[ARM_BIT] == 1'b0) && (ctl_rdata[FLUSH_BIT] == 1'b0));
   p_eoq_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && out_data[EOQ_B]) |=> !scan_active);
   p_last_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && entry_cnt == CNT_W'(1)) |=> (qstate == QS_IDLE));
   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push_ovf |=> push_ovf);

endmodule

// File: tb/cmdq_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmdq_trig_ctrl_tb_top;
   localparam int DEPTH = 4;
   localparam int CMD_W = 16;
   localparam int CW    = $clog2(DEPTH+1);

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ctl_wr;
   logic [5:0]       ctl_wdata;
   logic [7:0]       ctl_rdata;
   logic             push_valid;
   logic [CMD_W-1:0] push_data;
   logic             trig_in;
   logic             out_valid;
   logic             out_ready;
   logic [CMD_W-1:0] out_data;
   logic             scan_active;
   logic [CW-1:0]    entry_cnt;
   logic [1:0]       qstate;
   logic             mode_err;
   logic             push_ovf;

   always #2.5 clk = ~clk;

   cmdq_trig_ctrl #(.DEPTH(DEPTH), .CMD_W(CMD_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .push_valid(push_valid), .push_data(push_data),
      .trig_in(trig_in), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .scan_active(scan_active), .entry_cnt(entry_cnt),
      .qstate(qstate), .mode_err(mode_err), .push_ovf(push_ovf)
   );

   int               n_chk = 0;
   int               n_bad = 0;
   logic [CMD_W-1:0] exp_q[$];
   logic [CMD_W-1:0] mon_exp;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // driver: pushes a command and records it when the model has room (R10)
   task automatic push(input logic [CMD_W-1:0] d);
      @(negedge clk);
      push_valid = 1'b1;
      push_data  = d;
      if (exp_q.size() < DEPTH) exp_q.push_back(d);
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic wr(input logic [3:0] m, input logic arm, input logic fl);
      @(negedge clk);
      ctl_wr    = 1'b1;
      ctl_wdata = {fl, arm, m};
      @(negedge clk);
      ctl_wr    = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compares every hand-off against the scoreboard (R11)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               n_chk++;
               n_bad++;
               $display("FAIL R11 unexpected hand-off: actual %0d expected none", out_data);
            end else begin
               mon_exp = exp_q.pop_front();
               chk("R11", "out_data", int'(out_data), int'(mon_exp));
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; push_valid = 1'b0;
      push_data = '0; trig_in = 1'b0; out_ready = 1'b1;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset state
      chk("R3", "rdata after reset", ctl_rdata, 0);
      chk("R8", "qstate after reset", qstate, 0);
      chk("R10", "count after reset", entry_cnt, 0);
      chk("R10", "ovf after reset", push_ovf, 0);

      // load three commands while disabled
      push(16'h0011); push(16'h0022); push(16'h0033);
      chk("R11", "count after 3 pushes", entry_cnt, 3);
      chk("R8", "no valid while disabled", out_valid, 0);

      // R1: unknown mode code rejected
      wr(4'd9, 1'b0, 1'b0);
      chk("R1", "mode after code 9", ctl_rdata[3:0], 0);
      chk("R1", "err after code 9", mode_err, 1);

      // R2: arming while disabled does nothing
      wr(4'd0, 1'b1, 1'b0);
      chk("R2", "scan after arm in disabled", scan_active, 0);
      chk("R2", "count unchanged", entry_cnt, 3);

      // R3: mode write with arm=0 does not arm
      wr(4'd1, 1'b0, 1'b0);
      chk("R1", "mode 1 accepted", ctl_rdata[3:0], 1);
      chk("R3", "arm=0 leaves scan clear", scan_active, 0);
      chk("R8", "no valid before arm", out_valid, 0);

      // R2/R8/R9: software single scan drains the queue
      wr(4'd1, 1'b1, 1'b0);
      chk("R2", "scan after arm", scan_active, 1);
      chk("R3", "strobe bits read 0", ctl_rdata[5:4], 0);
      chk("R3", "scan bit in rdata", ctl_rdata[6], 1);
      chk("R8", "qstate triggered", qstate, 2);
      idle(4);
      chk("R9", "count after drain", entry_cnt, 0);
      chk("R9", "scan after last entry", scan_active, 0);
      chk("R9", "qstate idle after last", qstate, 0);

      // R6: illegal change while enabled
      wr(4'd2, 1'b0, 1'b0);
      chk("R6", "mode kept at 1", ctl_rdata[3:0], 1);
      chk("R6", "err set", ctl_rdata[7], 1);

      // R2/R5/R7/R4
      out_ready = 1'b0;
      push(16'h0044); push(16'h0055);
      wr(4'd1, 1'b1, 1'b0);
      chk("R2", "scan armed again", scan_active, 1);
      chk("R8", "valid with stored cmds", out_valid, 1);
      wr(4'd1, 1'b1, 1'b0);
      chk("R2", "re-arm keeps scan", scan_active, 1);
      chk("R2", "re-arm keeps count", entry_cnt, 2);
      wr(4'd1, 1'b0, 1'b1);
      chk("R5", "flush ignored while enabled", entry_cnt, 2);
      wr(4'd0, 1'b0, 1'b0);
      chk("R7", "scan cleared by disable", scan_active, 0);
      chk("R7", "qstate idle after disable", qstate, 0);
      chk("R7", "no valid after disable", out_valid, 0);
      chk("R7", "commands kept", entry_cnt, 2);
      wr(4'd0, 1'b0, 1'b1);
      exp_q.delete();
      chk("R4", "count after flush", entry_cnt, 0);
      out_ready = 1'b1;

      // R8/R9/R4: low-gated scan stops at end-of-queue marker
      push(16'h0066); push(16'h8077); push(16'h0088);
      trig_in = 1'b1;
      wr(4'd2, 1'b1, 1'b0);
      chk("R8", "low mode waiting", qstate, 1);
      chk("R8", "no valid while trig high", out_valid, 0);
      @(negedge clk);
      trig_in = 1'b0;
      idle(4);
      chk("R9", "one cmd left after marker", entry_cnt, 1);
      chk("R9", "scan cleared by marker", scan_active, 0);
      chk("R9", "qstate idle after marker", qstate, 0);

      // R8: high-gated scan
      wr(4'd0, 1'b0, 1'b0);
      wr(4'd3, 1'b1, 1'b0);
      chk("R8", "high mode waiting", qstate, 1);
      chk("R8", "no valid while trig low", out_valid, 0);
      @(negedge clk);
      trig_in = 1'b1;
      idle(3);
      chk("R9", "high scan drained", entry_cnt, 0);
      chk("R9", "scan clear after high scan", scan_active, 0);

      // R10: overflow
      wr(4'd0, 1'b0, 1'b0);
      out_ready = 1'b0;
      for (int i = 1; i <= 5; i++) push(16'h0100 + 16'(i));
      chk("R10", "count capped", entry_cnt, DEPTH);
      chk("R10", "ovf set", push_ovf, 1);
      wr(4'd1, 1'b1, 1'b0);
      out_ready = 1'b1;
      idle(6);
      chk("R10", "drained after overflow", entry_cnt, 0);
      chk("R9", "scan clear after drain", scan_active, 0);
      chk("R11", "scoreboard empty", exp_q.size(), 0);

      summary();
      $finish;
   end

endmodule